// File: doc/BRIEF.md
# Cascadable Complex Beamformer Slice

This block is one slice of a spatial filter that forms a beam from many receiver channels. On every valid sample instant it takes one complex sample per local channel and multiplies each by that channel's complex weight. It adds the products, rounds the total and clamps it. It then adds this local result to a partial sum coming from the slice upstream and passes the total downstream. Slices wired in a chain therefore act as one distributed adder tree, and the last slice in the chain carries the finished beam sample. Each beam, such as a sum beam or an azimuth beam, uses its own chain with its own weight set, and all chains see the same channel data.

An external weight solver writes weights one channel at a time into a shadow bank. A single update strobe copies the whole shadow bank into the active bank on one clock edge. As a result, no output sample is ever built from a mix of old and new weights. The incoming partial sum is expected a fixed number of cycles after the local samples. That offset is set by a parameter, and the slice delays its own result to meet it. The first slice of a chain is built with a start parameter that makes it ignore its partial-sum input.

Top module: `beam_slice`

## Requirements
- R1: For each valid sample instant, the local result is computed from the per-channel complex products, with real part ac−bd and imaginary part ad+bc. Here a and b are the sample's real and imaginary parts, and c and d are the active weight's real and imaginary parts. The products are summed over all channels. The sum has 2^(ROUND_SH−1) added, is shifted right arithmetically by ROUND_SH bits, and is clamped to SUM_W bits. Channel k occupies bits [k*SAMP_W +: SAMP_W] of the sample vectors.
- R2: Clamping saturates to the range −2^(SUM_W−1) to 2^(SUM_W−1)−1. It is applied to the local result and again after the partial-sum addition, and each part (real and imaginary) is clamped separately.
- R3: A sample captured on clock edge n produces its output registered on edge n+IN_LAG. The output valid is high for exactly one cycle per input sample.
- R4: In a non-start slice, the output equals the clamped sum of the aligned local result and the partial-sum input. The partial-sum input is sampled on edge n+IN_LAG. The output valid follows the partial-sum valid one cycle later, and the partial-sum valid only occurs when a local result is aligned with it.
- R5: With CASCADE_START set, the partial-sum data and valid inputs have no effect. The output valid then comes from the local sample valid.
- R6: A cycle with wLoad high writes wRe/wIm into shadow entry wAddr, which must be below NUM_CH. The output does not change until an update strobe.
- R7: wUpdate copies the entire shadow bank into the active bank on one edge. A sample captured on that same edge still uses the old set, and every later sample uses the new set. A load in the same cycle as the update reaches only the shadow bank.
- R8: While the output valid is low, the output data holds its previous value.
- R9: After reset, the output valid is low, the outputs are zero, and both weight banks are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sampValid | input | 1 | Channel samples valid this cycle |
| sampRe | input | NUM_CH*SAMP_W | Real parts of the channel samples, signed |
| sampIm | input | NUM_CH*SAMP_W | Imaginary parts of the channel samples, signed |
| wLoad | input | 1 | Write one weight into the shadow bank |
| wAddr | input | ADDR_W | Channel index of the weight write |
| wRe | input | WGT_W | Weight real part, signed |
| wIm | input | WGT_W | Weight imaginary part, signed |
| wUpdate | input | 1 | Copy the shadow bank into the active bank |
| psInValid | input | 1 | Upstream partial sum valid |
| psInRe | input | SUM_W | Upstream partial sum, real part |
| psInIm | input | SUM_W | Upstream partial sum, imaginary part |
| psOutValid | output | 1 | Downstream partial sum valid |
| psOutRe | output | SUM_W | Downstream partial sum, real part |
| psOutIm | output | SUM_W | Downstream partial sum, imaginary part |

## Verification
The hardest case to reach from the ports is the weight switch at the exact edge of an update. The bench has to show that the sample captured with the strobe still uses the old bank. It also has to show that a load in the same cycle lands only in the shadow bank.

The stimulus reaches this case with three chained slices. It issues updates together with live samples and with loads, both in directed steps and at random inside a gapped random stream. A bench model of both banks predicts every chained output. Saturation on both sides is driven by directed full-scale samples and weights, including a case where one slice clamps high and the next clamps low.

// File: rtl/beam_slice_pkg.sv
package beam_slice_pkg;

  // Strobes from the control path to the arithmetic path.
  typedef struct packed {
    logic load;    // write one shadow weight
    logic commit;  // shadow bank -> active bank
    logic prodEn;  // capture channel products
    logic sumEn;   // capture rounded local sum
    logic outEn;   // capture downstream partial sum
  } sliceStrobes_t;

endpackage

// File: rtl/beam_slice_ctrl.sv
module beam_slice_ctrl
  import beam_slice_pkg::*;
#(
  parameter int IN_LAG        = 3,
  parameter bit CASCADE_START = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sampValid,
  input  logic          psInValid,
  input  logic          wLoad,
  input  logic          wUpdate,
  output sliceStrobes_t strb,
  output logic          alignValid,
  output logic          outValid
);

  localparam int DLY = IN_LAG - 2;

  logic prodValid;
  logic sumValid;

  always_ff @(posedge clk) begin
    if (rst) begin
      prodValid <= 1'b0;
      sumValid  <= 1'b0;
    end else begin
      prodValid <= sampValid;
      sumValid  <= prodValid;
    end
  end

  generate
    if (DLY == 0) begin : g_noDelay
      assign alignValid = sumValid;
    end else begin : g_delay
      logic [DLY-1:0] validLine;
      always_ff @(posedge clk) begin
        if (rst) begin
          validLine <= '0;
        end else begin
          validLine[0] <= sumValid;
          for (int i = 1; i < DLY; i++) begin
            validLine[i] <= validLine[i-1];
          end
        end
      end
      assign alignValid = validLine[DLY-1];
    end
  endgenerate

  always_comb begin
    strb.load   = wLoad;
    strb.commit = wUpdate;
    strb.prodEn = sampValid;
    strb.sumEn  = prodValid;
    strb.outEn  = CASCADE_START ? alignValid : psInValid;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= strb.outEn;
  end

endmodule

// File: rtl/beam_slice_dp.sv
module beam_slice_dp
  import beam_slice_pkg::*;
#(
  parameter int NUM_CH        = 4,
  parameter int SAMP_W        = 12,
  parameter int WGT_W         = 12,
  parameter int SUM_W         = 20,
  parameter int ROUND_SH      = 8,
  parameter int IN_LAG        = 3,
  parameter bit CASCADE_START = 1'b0,
  parameter int ADDR_W        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  sliceStrobes_t              strb,
  input  logic [NUM_CH*SAMP_W-1:0]   sampRe,
  input  logic [NUM_CH*SAMP_W-1:0]   sampIm,
  input  logic [ADDR_W-1:0]          wAddr,
  input  logic signed [WGT_W-1:0]    wRe,
  input  logic signed [WGT_W-1:0]    wIm,
  input  logic signed [SUM_W-1:0]    psInRe,
  input  logic signed [SUM_W-1:0]    psInIm,
  output logic signed [SUM_W-1:0]    psOutRe,
  output logic signed [SUM_W-1:0]    psOutIm
);

  localparam int PW  = SAMP_W + WGT_W + 1;
  localparam int FW  = PW + $clog2(NUM_CH);
  localparam int CW  = (FW + 1 > SUM_W + 1) ? FW + 1 : SUM_W + 1;
  localparam int DLY = IN_LAG - 2;
  localparam logic signed [CW-1:0] TOP  = CW'({1'b0, {(SUM_W-1){1'b1}}});
  localparam logic signed [CW-1:0] BOT  = ~TOP;
  localparam logic signed [CW-1:0] HALF = CW'(1) << (ROUND_SH - 1);

  function automatic logic signed [SUM_W-1:0] clampTo(input logic signed [CW-1:0] v);
    if (v > TOP)      return TOP[SUM_W-1:0];
    else if (v < BOT) return BOT[SUM_W-1:0];
    else              return v[SUM_W-1:0];
  endfunction

  // Weight banks: shadow written by the load port, active used by the multipliers.
  logic signed [WGT_W-1:0] shadowRe [NUM_CH];
  logic signed [WGT_W-1:0] shadowIm [NUM_CH];
  logic signed [WGT_W-1:0] activeRe [NUM_CH];
  logic signed [WGT_W-1:0] activeIm [NUM_CH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NUM_CH; k++) begin
        shadowRe[k] <= '0;
        shadowIm[k] <= '0;
        activeRe[k] <= '0;
        activeIm[k] <= '0;
      end
    end else begin
      if (strb.commit) begin
        for (int k = 0; k < NUM_CH; k++) begin
          activeRe[k] <= shadowRe[k];
          activeIm[k] <= shadowIm[k];
        end
      end
      if (strb.load && (int'(wAddr) < NUM_CH)) begin
        shadowRe[wAddr] <= wRe;
        shadowIm[wAddr] <= wIm;
      end
    end
  end

  // One complex multiplier per channel, registered.
  logic signed [PW-1:0] prodRe [NUM_CH];
  logic signed [PW-1:0] prodIm [NUM_CH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NUM_CH; k++) begin
        prodRe[k] <= '0;
        prodIm[k] <= '0;
      end
    end else if (strb.prodEn) begin
      for (int k = 0; k < NUM_CH; k++) begin
        prodRe[k] <= PW'($signed(sampRe[k*SAMP_W +: SAMP_W])) * PW'(activeRe[k])
                   - PW'($signed(sampIm[k*SAMP_W +: SAMP_W])) * PW'(activeIm[k]);
        prodIm[k] <= PW'($signed(sampRe[k*SAMP_W +: SAMP_W])) * PW'(activeIm[k])
                   + PW'($signed(sampIm[k*SAMP_W +: SAMP_W])) * PW'(activeRe[k]);
      end
    end
  end

  // Local adder tree, rounding and clamping.
  logic signed [FW-1:0]    accRe, accIm;
  logic signed [CW-1:0]    rndRe, rndIm;
  logic signed [SUM_W-1:0] sumRe, sumIm;

  always_comb begin
    accRe = '0;
    accIm = '0;
    for (int k = 0; k < NUM_CH; k++) begin
      accRe = accRe + FW'(prodRe[k]);
      accIm = accIm + FW'(prodIm[k]);
    end
    rndRe = (CW'(accRe) + HALF) >>> ROUND_SH;
    rndIm = (CW'(accIm) + HALF) >>> ROUND_SH;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sumRe <= '0;
      sumIm <= '0;
    end else if (strb.sumEn) begin
      sumRe <= clampTo(rndRe);
      sumIm <= clampTo(rndIm);
    end
  end

  // Alignment of the local result with the upstream partial sum.
  logic signed [SUM_W-1:0] alignRe, alignIm;

  generate
    if (DLY == 0) begin : g_noDelay
      assign alignRe = sumRe;
      assign alignIm = sumIm;
    end else begin : g_delay
      logic signed [SUM_W-1:0] lineRe [DLY];
      logic signed [SUM_W-1:0] lineIm [DLY];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < DLY; i++) begin
            lineRe[i] <= '0;
            lineIm[i] <= '0;
          end
        end else begin
          lineRe[0] <= sumRe;
          lineIm[0] <= sumIm;
          for (int i = 1; i < DLY; i++) begin
            lineRe[i] <= lineRe[i-1];
            lineIm[i] <= lineIm[i-1];
          end
        end
      end
      assign alignRe = lineRe[DLY-1];
      assign alignIm = lineIm[DLY-1];
    end
  endgenerate

  // Cascade adder.
  logic signed [SUM_W-1:0] upRe, upIm;
  assign upRe = CASCADE_START ? '0 : psInRe;
  assign upIm = CASCADE_START ? '0 : psInIm;

  always_ff @(posedge clk) begin
    if (rst) begin
      psOutRe <= '0;
      psOutIm <= '0;
    end else if (strb.outEn) begin
      psOutRe <= clampTo(CW'(alignRe) + CW'(upRe));
      psOutIm <= clampTo(CW'(alignIm) + CW'(upIm));
    end
  end

endmodule

// File: rtl/beam_slice.sv
module beam_slice
  import beam_slice_pkg::*;
#(
  parameter int NUM_CH        = 4,
  parameter int SAMP_W        = 12,
  parameter int WGT_W         = 12,
  parameter int SUM_W         = 20,
  parameter int ROUND_SH      = 8,
  parameter int IN_LAG        = 3,
  parameter bit CASCADE_START = 1'b0,
  parameter int ADDR_W        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     sampValid,
  input  logic [NUM_CH*SAMP_W-1:0] sampRe,
  input  logic [NUM_CH*SAMP_W-1:0] sampIm,
  input  logic                     wLoad,
  input  logic [ADDR_W-1:0]        wAddr,
  input  logic signed [WGT_W-1:0]  wRe,
  input  logic signed [WGT_W-1:0]  wIm,
  input  logic                     wUpdate,
  input  logic                     psInValid,
  input  logic signed [SUM_W-1:0]  psInRe,
  input  logic signed [SUM_W-1:0]  psInIm,
  output logic                     psOutValid,
  output logic signed [SUM_W-1:0]  psOutRe,
  output logic signed [SUM_W-1:0]  psOutIm
);

  sliceStrobes_t strb;
  logic          alignValid;

  beam_slice_ctrl #(
    .IN_LAG       (IN_LAG),
    .CASCADE_START(CASCADE_START)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .sampValid (sampValid),
    .psInValid (psInValid),
    .wLoad     (wLoad),
    .wUpdate   (wUpdate),
    .strb      (strb),
    .alignValid(alignValid),
    .outValid  (psOutValid)
  );

  beam_slice_dp #(
    .NUM_CH       (NUM_CH),
    .SAMP_W       (SAMP_W),
    .WGT_W        (WGT_W),
    .SUM_W        (SUM_W),
    .ROUND_SH     (ROUND_SH),
    .IN_LAG       (IN_LAG),
    .CASCADE_START(CASCADE_START),
    .ADDR_W       (ADDR_W)
  ) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strb   (strb),
    .sampRe (sampRe),
    .sampIm (sampIm),
    .wAddr  (wAddr),
    .wRe    (wRe),
    .wIm    (wIm),
    .psInRe (psInRe),
    .psInIm (psInIm),
    .psOutRe(psOutRe),
    .psOutIm(psOutIm)
  );

endmodule

// File: rtl/beam_slice_check.sv
module beam_slice_check #(
  parameter int NUM_CH        = 4,
  parameter int SUM_W         = 20,
  parameter bit CASCADE_START = 1'b0,
  parameter int ADDR_W        = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              psInValid,
  input logic              alignValid,
  input logic              wLoad,
  input logic [ADDR_W-1:0] wAddr,
  input logic              psOutValid,
  input logic [SUM_W-1:0]  psOutRe,
  input logic [SUM_W-1:0]  psOutIm
);

  assert_valid_follow_R4: assert property (@(posedge clk) disable iff (rst)
    (!CASCADE_START && psInValid) |=> psOutValid);

  assert_no_stray_valid_R4: assert property (@(posedge clk) disable iff (rst)
    (!CASCADE_START && !psInValid) |=> !psOutValid);

  assert_upstream_aligned_R4: assert property (@(posedge clk) disable iff (rst)
    (!CASCADE_START && psInValid) |-> alignValid);

  assert_start_local_valid_R5: assert property (@(posedge clk) disable iff (rst)
    (CASCADE_START && alignValid) |=> psOutValid);

  assert_start_no_stray_R5: assert property (@(posedge clk) disable iff (rst)
    (CASCADE_START && !alignValid) |=> !psOutValid);

  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !psOutValid |-> ($stable(psOutRe) && $stable(psOutIm)));

  assert_addr_range_R6: assert property (@(posedge clk) disable iff (rst)
    wLoad |-> (int'(wAddr) < NUM_CH));

endmodule

bind beam_slice beam_slice_check #(
  .NUM_CH       (NUM_CH),
  .SUM_W        (SUM_W),
  .CASCADE_START(CASCADE_START),
  .ADDR_W       (ADDR_W)
) u_check (
  .clk       (clk),
  .rst       (rst),
  .psInValid (psInValid),
  .alignValid(alignValid),
  .wLoad     (wLoad),
  .wAddr     (wAddr),
  .psOutValid(psOutValid),
  .psOutRe   (psOutRe),
  .psOutIm   (psOutIm)
);

// File: tb/beam_slice_test.sv
module beam_slice_test;

  localparam int NCH  = 4;
  localparam int SW   = 12;
  localparam int WW   = 12;
  localparam int SUMW = 16;
  localparam int RSH  = 8;
  localparam int NS   = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;  // 250 MHz

  logic                   sampValid = 1'b0;
  logic [NCH*SW-1:0]      bRe [NS];
  logic [NCH*SW-1:0]      bIm [NS];
  logic [NS-1:0]          wLoad = '0;
  logic [1:0]             wAddr = '0;
  logic signed [WW-1:0]   wRe = '0, wIm = '0;
  logic                   wUpdate = 1'b0;
  logic                   junkValid = 1'b0;
  logic signed [SUMW-1:0] junkRe = '0, junkIm = '0;

  logic                   v0, v1, outValid;
  logic signed [SUMW-1:0] r0, i0, r1, i1, outRe, outIm;

  beam_slice #(.NUM_CH(NCH), .SAMP_W(SW), .WGT_W(WW), .SUM_W(SUMW), .ROUND_SH(RSH),
               .IN_LAG(2), .CASCADE_START(1'b1)) s0 (
    .clk(clk), .rst(rst), .sampValid(sampValid), .sampRe(bRe[0]), .sampIm(bIm[0]),
    .wLoad(wLoad[0]), .wAddr(wAddr), .wRe(wRe), .wIm(wIm), .wUpdate(wUpdate),
    .psInValid(junkValid), .psInRe(junkRe), .psInIm(junkIm),
    .psOutValid(v0), .psOutRe(r0), .psOutIm(i0));

  beam_slice #(.NUM_CH(NCH), .SAMP_W(SW), .WGT_W(WW), .SUM_W(SUMW), .ROUND_SH(RSH),
               .IN_LAG(3), .CASCADE_START(1'b0)) s1 (
    .clk(clk), .rst(rst), .sampValid(sampValid), .sampRe(bRe[1]), .sampIm(bIm[1]),
    .wLoad(wLoad[1]), .wAddr(wAddr), .wRe(wRe), .wIm(wIm), .wUpdate(wUpdate),
    .psInValid(v0), .psInRe(r0), .psInIm(i0),
    .psOutValid(v1), .psOutRe(r1), .psOutIm(i1));

  beam_slice #(.NUM_CH(NCH), .SAMP_W(SW), .WGT_W(WW), .SUM_W(SUMW), .ROUND_SH(RSH),
               .IN_LAG(4), .CASCADE_START(1'b0)) uut (
    .clk(clk), .rst(rst), .sampValid(sampValid), .sampRe(bRe[2]), .sampIm(bIm[2]),
    .wLoad(wLoad[2]), .wAddr(wAddr), .wRe(wRe), .wIm(wIm), .wUpdate(wUpdate),
    .psInValid(v1), .psInRe(r1), .psInIm(i1),
    .psOutValid(outValid), .psOutRe(outRe), .psOutIm(outIm));

  // Bench model state.
  int sRe [NS][NCH];
  int sIm [NS][NCH];
  int shR [NS][NCH];
  int shI [NS][NCH];
  int acR [NS][NCH];
  int acI [NS][NCH];

  typedef struct {
    longint re;
    longint im;
    int     due;
    string  tag;
  } expect_t;

  expect_t q[$];
  int  edgeCount = 0;
  int  nChecks = 0;
  int  nFail = 0;
  bit  monitorOn = 1'b0;
  bit  done = 1'b0;
  longint lastRe = 0, lastIm = 0;

  always @(posedge clk) edgeCount <= edgeCount + 1;

  task automatic check(input string tag, input longint got, input longint exp);
    nChecks++;
    if (got != exp) begin
      nFail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic longint clampL(input longint v);
    longint hi = (longint'(1) <<< (SUMW - 1)) - 1;
    longint lo = -(longint'(1) <<< (SUMW - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  function automatic longint roundL(input longint v);
    return (v + (longint'(1) <<< (RSH - 1))) >>> RSH;
  endfunction

  function automatic longint localRe(input int s);
    longint acc = 0;
    for (int k = 0; k < NCH; k++)
      acc += longint'(sRe[s][k]) * acR[s][k] - longint'(sIm[s][k]) * acI[s][k];
    return clampL(roundL(acc));
  endfunction

  function automatic longint localIm(input int s);
    longint acc = 0;
    for (int k = 0; k < NCH; k++)
      acc += longint'(sRe[s][k]) * acI[s][k] + longint'(sIm[s][k]) * acR[s][k];
    return clampL(roundL(acc));
  endfunction

  function automatic int rndS();
    return int'($urandom_range(4095)) - 2048;
  endfunction

  task automatic randomSamples();
    for (int s = 0; s < NS; s++)
      for (int k = 0; k < NCH; k++) begin
        sRe[s][k] = rndS();
        sIm[s][k] = rndS();
      end
  endtask

  task automatic fillSamples(input int s, input int re, input int im);
    for (int k = 0; k < NCH; k++) begin
      sRe[s][k] = re;
      sIm[s][k] = im;
    end
  endtask

  // One input cycle: samples, optional update, optional load into slice ls.
  task automatic driveCycle(input bit v, input bit upd, input int ls, input int ch,
                            input int wr, input int wi, input string tag);
    expect_t e;
    longint pr, pi;
    @(negedge clk);
    for (int s = 0; s < NS; s++)
      for (int k = 0; k < NCH; k++) begin
        bRe[s][k*SW +: SW] = sRe[s][k][SW-1:0];
        bIm[s][k*SW +: SW] = sIm[s][k][SW-1:0];
      end
    sampValid = v;
    wUpdate   = upd;
    wLoad     = (ls >= 0) ? NS'(1 << ls) : '0;
    wAddr     = 2'(ch);
    wRe       = WW'(wr);
    wIm       = WW'(wi);
    junkValid = 1'($urandom_range(1));
    junkRe    = SUMW'($urandom);
    junkIm    = SUMW'($urandom);
    if (v) begin
      pr = localRe(0);
      pi = localIm(0);
      for (int s = 1; s < NS; s++) begin
        pr = clampL(pr + localRe(s));
        pi = clampL(pi + localIm(s));
      end
      e.re = pr; e.im = pi; e.due = edgeCount + 5; e.tag = tag;
      q.push_back(e);
    end
    if (upd)
      for (int s = 0; s < NS; s++)
        for (int k = 0; k < NCH; k++) begin
          acR[s][k] = shR[s][k];
          acI[s][k] = shI[s][k];
        end
    if (ls >= 0) begin
      shR[ls][ch] = wr;
      shI[ls][ch] = wi;
    end
  endtask

  task automatic loadAll(input int wr, input int wi, input bit ch0Only);
    for (int s = 0; s < NS; s++)
      for (int k = 0; k < NCH; k++)
        driveCycle(1'b0, 1'b0, s, k, (ch0Only && k != 0) ? 0 : wr,
                   (ch0Only && k != 0) ? 0 : wi, "R6");
    driveCycle(1'b0, 1'b1, -1, 0, 0, 0, "R7");
  endtask

  // Output monitor.
  always @(negedge clk) begin
    if (monitorOn) begin
      if (outValid) begin
        if (q.size() == 0 || q[0].due != edgeCount) begin
          nChecks++;
          nFail++;
          $display("FAIL R3: unexpected valid at edge %0d, expected due %0d", edgeCount,
                   (q.size() == 0) ? -1 : q[0].due);
        end else begin
          check({q[0].tag, " real"}, longint'(outRe), q[0].re);
          check({q[0].tag, " imag"}, longint'(outIm), q[0].im);
          void'(q.pop_front());
        end
      end else begin
        if (q.size() != 0 && q[0].due <= edgeCount) begin
          nChecks++;
          nFail++;
          $display("FAIL R3: valid missing at edge %0d, expected 1 got 0", edgeCount);
          void'(q.pop_front());
        end
        check("R8 hold real", longint'(outRe), lastRe);
        check("R8 hold imag", longint'(outIm), lastIm);
      end
      lastRe = longint'(outRe);
      lastIm = longint'(outIm);
    end
  end

  initial begin
    void'($urandom(32'd7331));
    for (int s = 0; s < NS; s++) begin
      bRe[s] = '0;
      bIm[s] = '0;
      for (int k = 0; k < NCH; k++) begin
        sRe[s][k] = 0; sIm[s][k] = 0;
        shR[s][k] = 0; shI[s][k] = 0;
        acR[s][k] = 0; acI[s][k] = 0;
      end
    end
    repeat (4) @(negedge clk);
    // R9: reset state
    check("R9 valid", longint'(outValid), 0);
    check("R9 real", longint'(outRe), 0);
    check("R9 imag", longint'(outIm), 0);
    rst = 1'b0;
    monitorOn = 1'b1;

    // R9: weights are zero after reset, so the beam is zero.
    for (int n = 0; n < 6; n++) begin
      randomSamples();
      driveCycle(1'b1, 1'b0, -1, 0, 0, 0, "R9");
    end

    // R6: loads without update leave the output unchanged.
    for (int s = 0; s < NS; s++)
      for (int k = 0; k < NCH; k++) begin
        randomSamples();
        driveCycle(1'b1, 1'b0, s, k, rndS(), rndS(), "R6");
      end

    // R7: sample on the update edge uses the old bank, later ones the new bank.
    randomSamples();
    driveCycle(1'b1, 1'b1, -1, 0, 0, 0, "R7 old bank at strobe");
    for (int n = 0; n < 3; n++) begin
      randomSamples();
      driveCycle(1'b1, 1'b0, -1, 0, 0, 0, "R7 new bank after strobe");
    end

    // R7: load in the same cycle as an update reaches the shadow bank only.
    randomSamples();
    driveCycle(1'b1, 1'b1, 1, 2, 1000, -1000, "R7 load with update");
    randomSamples();
    driveCycle(1'b1, 1'b0, -1, 0, 0, 0, "R7 load not yet active");
    randomSamples();
    driveCycle(1'b1, 1'b1, -1, 0, 0, 0, "R7 second strobe");
    randomSamples();
    driveCycle(1'b1, 1'b0, -1, 0, 0, 0, "R7 load now active");

    // R1, R4, R5: random stream with gaps, random loads and updates.
    for (int n = 0; n < 400; n++) begin
      bit v   = ($urandom_range(3) != 0);
      bit upd = ($urandom_range(30) == 0);
      int ls  = ($urandom_range(5) == 0) ? int'($urandom_range(NS - 1)) : -1;
      randomSamples();
      driveCycle(v, upd, ls, int'($urandom_range(NCH - 1)), rndS(), rndS(), "R1,R4,R5 random");
    end

    // R2: positive clamp in every slice.
    loadAll(-2048, 0, 1'b0);
    for (int s = 0; s < NS; s++) fillSamples(s, -2048, 0);
    driveCycle(1'b1, 1'b0, -1, 0, 0, 0, "R2 positive clamp");
    // R2: negative clamp.
    for (int s = 0; s < NS; s++) fillSamples(s, 2047, 0);
    driveCycle(1'b1, 1'b0, -1, 0, 0, 0, "R2 negative clamp");
    // R2: first slice clamps high, second clamps low, third adds zero.
    fillSamples(0, -2048, 0);
    fillSamples(1, 2047, 0);
    fillSamples(2, 0, 0);
    driveCycle(1'b1, 1'b0, -1, 0, 0, 0, "R2 mixed clamps");
    // R2: imaginary path clamp.
    for (int s = 0; s < NS; s++) fillSamples(s, 0, -2048);
    driveCycle(1'b1, 1'b0, -1, 0, 0, 0, "R2 imaginary clamp");

    // R1: unit weight on channel 0 passes that sample through.
    loadAll(1 << RSH, 0, 1'b1);
    for (int n = 0; n < 8; n++) begin
      randomSamples();
      driveCycle(1'b1, 1'b0, -1, 0, 0, 0, "R1 unit weight");
    end

    // Drain.
    driveCycle(1'b0, 1'b0, -1, 0, 0, 0, "idle");
    repeat (10) @(negedge clk);
    check("R3 all samples produced", longint'(q.size()), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

endmodule